// File: doc/BRIEF.md
# Read-to-Clear Interrupt Status Register

This block is the device-side holding register for legacy level interrupts. It collects two event sources, a configuration-change event and a queue event, into sticky pending bits. A host-side read strobe returns the whole status byte and clears it in the same step, so the driver reads and acknowledges in one access.

When message-signalled interrupts are off, the block drives an interrupt-status flag equal to the OR of the pending bits. It also drives a level interrupt line that follows this flag unless the interrupt-disable mask is set. When message-signalled interrupts are on, both outputs are held low, though the pending bits keep collecting events. The reset input is asynchronous and active low. Its release is synchronised inside the block.

Top module: `irq_status_top`

## Requirements
- R1: A one-cycle pulse on `cfg_evt` sets bit 0 of the status byte, and a pulse on `queue_evt` sets bit 1. Both bits are visible after the next rising clock edge.
- R2: A set bit stays set, with no further event, until a read clears it.
- R3: A read strobe makes `rd_data` show the status byte from before that clock edge, valid from that edge onward. Bits 7 to 2 read as zero. `rd_data` holds its value until the next read.
- R4: A read clears every pending bit at the same edge that captures the read data.
- R5: If an event arrives in the same cycle as a read, the read returns the old value and the new event is pending afterwards.
- R6: With `msi_en` low, `irq_status` is high exactly when at least one pending bit is set.
- R7: `intx_line` equals `irq_status` while `intx_mask` is low and is low while `intx_mask` is high. The mask does not change `irq_status`.
- R8: With `msi_en` high, `irq_status` and `intx_line` are both low. Events still set pending bits, which a later read returns.
- R9: While `rst_n` is low, the pending bits and `rd_data` are zero and both interrupt outputs are low. Asserting reset takes effect without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_evt | input | 1 | Configuration-change event pulse |
| queue_evt | input | 1 | Queue event pulse |
| rd_stb | input | 1 | Status read strobe; clears on the same edge |
| rd_data | output | 8 | Status byte captured by the last read |
| msi_en | input | 1 | Message-signalled interrupts enabled |
| intx_mask | input | 1 | Interrupt-disable mask for the level line |
| irq_status | output | 1 | OR of pending bits, forced low when `msi_en` is high |
| intx_line | output | 1 | Level interrupt line |

## Verification
The hardest case to reach is an event pulse landing in the same cycle as a read strobe. At that edge the old byte must be returned while the new bit survives the clear. The vector table drives this on purpose: it strobes a read together with one event, and again together with both events on an empty register. A follow-up read confirms that exactly the coincident events remain. A second subtle case is events collected while message-signalled interrupts are enabled. The bench leaves the outputs silent during that phase, then switches the mode off and expects the interrupt to appear at once.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int unsigned STATUS_W  = 8;
  localparam int unsigned NUM_SRC   = 2;
  localparam int unsigned CFG_BIT   = 0;
  localparam int unsigned QUEUE_BIT = 1;
endpackage

// File: rtl/isr_pending_bits.sv
module isr_pending_bits #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] set_vec,
  input  logic               clr,
  output logic [NUM_SRC-1:0] pend_q
);
  logic [NUM_SRC-1:0] pend_d;

  // a clear drops old bits; events of the same cycle survive it
  always_comb begin
    pend_d = (clr ? '0 : pend_q) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assert_clear_keeps_new_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pend_q == $past(set_vec));

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit_chk
    assert_event_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> pend_q[i]);
    assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && pend_q[i]) |=> pend_q[i]);
  end
endmodule

// File: rtl/isr_read_port.sv
module isr_read_port #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_stb,
  input  logic [NUM_SRC-1:0] pend,
  output logic [DATA_W-1:0]  rd_data
);
  localparam int unsigned PAD_W = DATA_W - NUM_SRC;

  logic [DATA_W-1:0] data_d;

  always_comb begin
    data_d = {{PAD_W{1'b0}}, pend};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= data_d;
  end

  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
endmodule

// File: rtl/isr_legacy_irq.sv
module isr_legacy_irq #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] pend,
  input  logic               msi_en,
  input  logic               intx_mask,
  output logic               irq_status,
  output logic               intx_line
);
  always_comb begin
    irq_status = !msi_en && (|pend);
    intx_line  = irq_status && !intx_mask;
  end

  assert_msi_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_en |-> (!irq_status && !intx_line));
  assert_mask_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    intx_mask |-> !intx_line);
  assert_pending_raises_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_en && !intx_mask && (pend != '0)) |-> (irq_status && intx_line));
endmodule

// File: rtl/irq_status_top.sv
module irq_status_top #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_evt,
  input  logic                          queue_evt,
  input  logic                          rd_stb,
  output logic [isr_pkg::STATUS_W-1:0]  rd_data,
  input  logic                          msi_en,
  input  logic                          intx_mask,
  output logic                          irq_status,
  output logic                          intx_line
);
  import isr_pkg::*;

  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;
  logic [NUM_SRC-1:0]     set_vec;
  logic [NUM_SRC-1:0]     pend;

  // assert asynchronously, release after SYNC_STAGES edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  always_comb begin
    set_vec            = '0;
    set_vec[CFG_BIT]   = cfg_evt;
    set_vec[QUEUE_BIT] = queue_evt;
  end

  isr_pending_bits #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .set_vec(set_vec),
    .clr    (rd_stb),
    .pend_q (pend)
  );

  isr_read_port #(.NUM_SRC(NUM_SRC), .DATA_W(STATUS_W)) u_rd (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .rd_stb (rd_stb),
    .pend   (pend),
    .rd_data(rd_data)
  );

  isr_legacy_irq #(.NUM_SRC(NUM_SRC)) u_irq (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .pend      (pend),
    .msi_en    (msi_en),
    .intx_mask (intx_mask),
    .irq_status(irq_status),
    .intx_line (intx_line)
  );

  assert_read_value_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stb |=> rd_data == {{(STATUS_W-NUM_SRC){1'b0}}, $past(pend)});
  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_stb && !cfg_evt && !queue_evt) |=> !irq_status);
  assert_reset_quiet_R9: assert property (@(posedge clk)
    !rst_n |-> (!irq_status && !intx_line && rd_data == '0));
endmodule

// File: tb/test_irq_status_top.sv
module test_irq_status_top;
  typedef struct packed {
    logic       cfg;
    logic       q;
    logic       rd;
    logic       msi;
    logic       mask;
    logic [7:0] exp_rd;
    logic       exp_st;
    logic       exp_line;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b1}, // R1 cfg sets bit0
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,1'b1}, // R2 holds
    '{1'b0,1'b1,1'b0,1'b0,1'b0,8'h00,1'b1,1'b1}, // R1 queue sets bit1
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h03,1'b0,1'b0}, // R3 R4 read both
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h03,1'b0,1'b0}, // R3 data held
    '{1'b0,1'b1,1'b0,1'b0,1'b1,8'h03,1'b1,1'b0}, // R7 masked
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h03,1'b1,1'b1}, // R7 unmasked
    '{1'b1,1'b0,1'b1,1'b0,1'b0,8'h02,1'b1,1'b1}, // R5 read + cfg
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h01,1'b0,1'b0}, // R5 cfg kept
    '{1'b1,1'b0,1'b0,1'b1,1'b0,8'h01,1'b0,1'b0}, // R8 msi silent
    '{1'b0,1'b1,1'b0,1'b1,1'b0,8'h01,1'b0,1'b0}, // R8 msi silent
    '{1'b0,1'b0,1'b0,1'b0,1'b0,8'h01,1'b1,1'b1}, // R6 msi off
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h03,1'b0,1'b0}, // R8 latched
    '{1'b0,1'b0,1'b1,1'b0,1'b0,8'h00,1'b0,1'b0}, // R4 empty
    '{1'b1,1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,1'b1}, // R5 both on read
    '{1'b0,1'b0,1'b1,1'b0,1'b1,8'h03,1'b0,1'b0}  // R5 R7 read masked
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_evt, queue_evt, rd_stb, msi_en, intx_mask;
  logic [7:0] rd_data;
  logic       irq_status, intx_line;
  int         n_vec = 0;
  int         n_err = 0;

  always #10 clk = ~clk;

  irq_status_top i_irq_status_top (
    .clk(clk), .rst_n(rst_n), .cfg_evt(cfg_evt), .queue_evt(queue_evt),
    .rd_stb(rd_stb), .rd_data(rd_data), .msi_en(msi_en),
    .intx_mask(intx_mask), .irq_status(irq_status), .intx_line(intx_line)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic q, input logic r,
                       input logic m, input logic k);
    cfg_evt = c; queue_evt = q; rd_stb = r; msi_en = m; intx_mask = k;
  endtask

  initial begin
    #(20 * 5000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R9 reset rd_data", rd_data, 8'h00);
    check("R9 reset irq_status", {7'd0, irq_status}, 8'h00);
    check("R9 reset intx_line", {7'd0, intx_line}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i].cfg, VECS[i].q, VECS[i].rd, VECS[i].msi, VECS[i].mask);
      @(negedge clk);
      check($sformatf("R1-vec%0d rd_data", i), rd_data, VECS[i].exp_rd);
      check($sformatf("R6-vec%0d irq_status", i), {7'd0, irq_status}, {7'd0, VECS[i].exp_st});
      check($sformatf("R7-vec%0d intx_line", i), {7'd0, intx_line}, {7'd0, VECS[i].exp_line});
    end

    // R9: asynchronous reset with bits pending
    drive(1, 1, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    #3 rst_n = 1'b0;
    #1;
    check("R9 async irq_status", {7'd0, irq_status}, 8'h00);
    check("R9 async intx_line", {7'd0, intx_line}, 8'h00);
    check("R9 async rd_data", rd_data, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(0, 0, 1, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    check("R9 cleared after reset", rd_data, 8'h00);

    // R2: long hold then read
    drive(0, 1, 0, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    repeat (20) @(negedge clk);
    check("R2 long hold line", {7'd0, intx_line}, 8'h01);
    drive(0, 0, 1, 0, 0);
    @(negedge clk);
    drive(0, 0, 0, 0, 0);
    check("R2 long hold value", rd_data, 8'h02);
    check("R4 line drops", {7'd0, intx_line}, 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule